// File: doc/BRIEF.md
# Manchester Line Encoder with Frame Delimiters

This block turns a stream of data bits into a Manchester-coded, single-ended serial line signal for a 100 Mb/s differential field-bus link. It runs at 200 MHz and drives one half-bit on every clock, so each data bit takes two clocks. Between frames the line carries a steady idle pattern. Each frame is framed by coding violations: a run of three high half-bits marks the start and a run of three low half-bits marks the end. No valid Manchester data stream can produce either run.

An eight-state half-bit sequencer drives the line. The states, with their indicator codes, are IDLE_LO (0), IDLE_HI (1), SOF_A (2), SOF_B (3), BIT_FIRST (4), BIT_SECOND (5), EOF_A (6) and EOF_B (7). The transitions are:

- IDLE_LO→IDLE_HI
- IDLE_HI→SOF_A when `bit_valid` is high, otherwise IDLE_HI→IDLE_LO
- SOF_A→SOF_B, then SOF_B→BIT_FIRST
- BIT_FIRST→BIT_SECOND
- BIT_SECOND→BIT_FIRST when `bit_valid` is high, otherwise BIT_SECOND→EOF_A
- EOF_A→EOF_B, then EOF_B→IDLE_LO

The upstream source holds `bit_valid` high with the first bit on `bit_in` to request a frame. `bit_take` pulses during BIT_SECOND to say that the current bit is consumed. Before the clock edge that ends BIT_SECOND, the source either presents the next bit with `bit_valid` still high or drops `bit_valid` to close the frame. The new bit must then stay stable through the following BIT_FIRST.

Top module: `manch_line_tx`

## Requirements
- R1: A data bit of 0 goes out as half-bits 0 then 1, and a data bit of 1 as 1 then 0. BIT_FIRST drives the current `bit_in`, and BIT_SECOND drives the inverse of the bit that was driven in BIT_FIRST.
- R2: Between frames the line alternates 0 in IDLE_LO and 1 in IDLE_HI. If `bit_valid` is low in IDLE_HI, the next state is IDLE_LO.
- R3: Each state lasts exactly one clock. `phase` reports the current state with the codes IDLE_LO=0, IDLE_HI=1, SOF_A=2, SOF_B=3, BIT_FIRST=4, BIT_SECOND=5, EOF_A=6, EOF_B=7, and the state follows the transitions listed above.
- R4: If `bit_valid` is high in IDLE_HI, the next states are SOF_A, SOF_B and then BIT_FIRST. SOF_A and SOF_B both drive 1, so together with IDLE_HI the line shows three high half-bits before the first data half-bit.
- R5: If `bit_valid` is low in BIT_SECOND, the next states are EOF_A, EOF_B and then IDLE_LO, all driving 0. This gives at least three low half-bits whatever the last data bit was.
- R6: `bit_take` is high in BIT_SECOND and low in every other state. If `bit_valid` is high in BIT_SECOND, the next state is BIT_FIRST.
- R7: `bit_valid` is ignored in every state except IDLE_HI and BIT_SECOND. A high level seen only in IDLE_LO does not start a frame, and a low level seen only in BIT_FIRST does not end one.
- R8: An active-low asynchronous reset forces IDLE_LO at once, with `line_out` low and `bit_take` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz half-bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A bit is waiting (frame request or continuation) |
| bit_in | input | 1 | Current data bit |
| bit_take | output | 1 | Current bit consumed (high in BIT_SECOND) |
| line_out | output | 1 | Single-ended Manchester line signal |
| phase | output | 3 | Current sequencer state code |

## Verification
`line_out`, `bit_take` and `phase` are decoded from the state register, so each one changes one clock edge after the input that caused it. The exception is BIT_FIRST, where `line_out` follows `bit_in` in the same cycle. A frame request made in IDLE_LO therefore shows up as SOF_A two edges later, and a low `bit_valid` in BIT_SECOND shows up as EOF_A one edge later. The bench builds the full expected half-bit, state and strobe sequence for each frame from the rules above. It compares that sequence with the outputs at every falling edge, and it changes inputs only after sampling, in the middle of the cycle, so each value is checked in the cycle it is due.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;
    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        IDLE_LO    = 3'd0,
        IDLE_HI    = 3'd1,
        SOF_A      = 3'd2,
        SOF_B      = 3'd3,
        BIT_FIRST  = 3'd4,
        BIT_SECOND = 3'd5,
        EOF_A      = 3'd6,
        EOF_B      = 3'd7
    } tx_state_e;
endpackage

// File: rtl/manch_tx_seq.sv
module manch_tx_seq
    import manch_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_valid,
    output tx_state_e state
);
    tx_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE_LO;
        else        state <= state_nx;
    end

    // next-state decode; bit_valid is looked at only in IDLE_HI and BIT_SECOND
    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE_LO:    state_nx = IDLE_HI;
            IDLE_HI:    state_nx = bit_valid ? SOF_A : IDLE_LO;
            SOF_A:      state_nx = SOF_B;
            SOF_B:      state_nx = BIT_FIRST;
            BIT_FIRST:  state_nx = BIT_SECOND;
            BIT_SECOND: state_nx = bit_valid ? BIT_FIRST : EOF_A;
            EOF_A:      state_nx = EOF_B;
            EOF_B:      state_nx = IDLE_LO;
        endcase
    end

    p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IDLE_HI && !bit_valid) |=> state == IDLE_LO);
    p_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == IDLE_LO |=> state == IDLE_HI);
    p_sof_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IDLE_HI && bit_valid) |=> state == SOF_A);
    p_sof_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == SOF_A |=> state == SOF_B);
    p_eof_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == EOF_B |=> state == IDLE_LO);
    p_bit_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == BIT_FIRST |=> state == BIT_SECOND);
endmodule

// File: rtl/manch_tx_sym.sv
module manch_tx_sym
    import manch_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tx_state_e state,
    input  logic      bit_in,
    output logic      line_out,
    output logic      bit_take
);
    logic held_bit;

    // keep the bit sent in BIT_FIRST so BIT_SECOND can drive its inverse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  held_bit <= 1'b0;
        else if (state == BIT_FIRST) held_bit <= bit_in;
    end

    // half-bit output decode
    always_comb begin
        line_out = 1'b0;
        bit_take = 1'b0;
        unique case (state)
            IDLE_LO:    line_out = 1'b0;
            IDLE_HI:    line_out = 1'b1;
            SOF_A:      line_out = 1'b1;
            SOF_B:      line_out = 1'b1;
            BIT_FIRST:  line_out = bit_in;
            BIT_SECOND: begin
                line_out = ~held_bit;
                bit_take = 1'b1;
            end
            EOF_A:      line_out = 1'b0;
            EOF_B:      line_out = 1'b0;
        endcase
    end

    p_mid_transition_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == BIT_SECOND |-> line_out != $past(line_out));
    p_three_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == SOF_B |-> (line_out && $past(line_out) && $past(line_out, 2)));
    p_three_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IDLE_LO && $past(state) == EOF_B)
            |-> (!line_out && !$past(line_out) && !$past(line_out, 2)));
endmodule

// File: rtl/manch_line_tx.sv
module manch_line_tx
    import manch_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic               bit_take,
    output logic               line_out,
    output logic [PHASE_W-1:0] phase
);
    tx_state_e state;

    manch_tx_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .state     (state)
    );

    manch_tx_sym i_sym (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .bit_in   (bit_in),
        .line_out (line_out),
        .bit_take (bit_take)
    );

    assign phase = state;

    p_take_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_take |=> (phase == BIT_FIRST || phase == EOF_A));
    p_take_continue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_take && bit_valid) |=> phase == BIT_FIRST);
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> (!line_out && !bit_take && phase == IDLE_LO));
endmodule

// File: tb/test_manch_line_tx.sv
module test_manch_line_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_take;
    logic       line_out;
    logic [2:0] phase;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    manch_line_tx i_manch_line_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .bit_take  (bit_take),
        .line_out  (line_out),
        .phase     (phase)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // bring the sequencer to IDLE_LO with no request pending
    task automatic wait_idle_lo();
        bit_valid = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (phase == 3'd0) break;
            @(negedge clk);
        end
    endtask

    function automatic string line_req(input logic [2:0] st);
        if (st <= 3'd1) return "R2";
        if (st <= 3'd3) return "R4";
        if (st <= 3'd5) return "R1";
        return "R5";
    endfunction

    // send one frame of n bits; glitch_at >= 0 drops bit_valid during BIT_FIRST of that bit (R7)
    task automatic run_frame(input logic [31:0] bits, input int n, input int glitch_at);
        logic [2:0] es [0:127];
        logic       el [0:127];
        logic       et [0:127];
        int k = 0;
        int idx = 0;
        wait_idle_lo();
        es[k] = 3'd0; el[k] = 1'b0; et[k] = 1'b0; k++;
        es[k] = 3'd1; el[k] = 1'b1; et[k] = 1'b0; k++;
        es[k] = 3'd2; el[k] = 1'b1; et[k] = 1'b0; k++;
        es[k] = 3'd3; el[k] = 1'b1; et[k] = 1'b0; k++;
        for (int i = 0; i < n; i++) begin
            es[k] = 3'd4; el[k] = bits[i];  et[k] = 1'b0; k++;
            es[k] = 3'd5; el[k] = ~bits[i]; et[k] = 1'b1; k++;
        end
        es[k] = 3'd6; el[k] = 1'b0; et[k] = 1'b0; k++;
        es[k] = 3'd7; el[k] = 1'b0; et[k] = 1'b0; k++;
        es[k] = 3'd0; el[k] = 1'b0; et[k] = 1'b0; k++;
        es[k] = 3'd1; el[k] = 1'b1; et[k] = 1'b0; k++;
        es[k] = 3'd0; el[k] = 1'b0; et[k] = 1'b0; k++;
        bit_in = bits[0];
        for (int s = 0; s < k; s++) begin
            chk(phase == es[s], "R3", "phase", int'(phase), int'(es[s]));
            chk(line_out == el[s], line_req(es[s]), "line_out", int'(line_out), int'(el[s]));
            chk(bit_take == et[s], "R6", "bit_take", int'(bit_take), int'(et[s]));
            if (bit_take) begin
                idx++;
                bit_in = (idx < n) ? bits[idx] : 1'b0;
            end
            bit_valid = (idx < n);
            if (es[s] == 3'd4 && idx == glitch_at) bit_valid = 1'b0; // R7: ignored in BIT_FIRST
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(phase == 3'd0, "R8", "reset phase", int'(phase), 0);
        chk(line_out == 1'b0, "R8", "reset line", int'(line_out), 0);
        chk(bit_take == 1'b0, "R8", "reset take", int'(bit_take), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        wait_idle_lo();
        for (int i = 0; i < 10; i++) begin
            chk(phase == 3'(i % 2), "R3", "idle phase", int'(phase), i % 2);
            chk(line_out == 1'(i % 2), "R2", "idle line", int'(line_out), i % 2);
            @(negedge clk);
        end
    endtask

    // R7: request visible only during IDLE_LO must not start a frame
    task automatic t_idle_lo_pulse();
        wait_idle_lo();
        bit_valid = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        chk(phase == 3'd1, "R7", "pulse phase IDLE_HI", int'(phase), 1);
        @(negedge clk);
        chk(phase == 3'd0, "R7", "pulse ignored phase", int'(phase), 0);
        chk(line_out == 1'b0, "R7", "pulse ignored line", int'(line_out), 0);
        @(negedge clk);
        chk(phase == 3'd1, "R7", "pulse ignored next", int'(phase), 1);
    endtask

    task automatic t_mid_reset();
        wait_idle_lo();
        bit_valid = 1'b1;
        bit_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (phase == 3'd4) break;
            @(negedge clk);
        end
        rst_n = 1'b0;
        #1;
        chk(phase == 3'd0, "R8", "async reset phase", int'(phase), 0);
        chk(line_out == 1'b0, "R8", "async reset line", int'(line_out), 0);
        chk(bit_take == 1'b0, "R8", "async reset take", int'(bit_take), 0);
        bit_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        run_frame(32'h0, 1, -1);
        run_frame(32'h1, 1, -1);
        run_frame(32'hA5, 8, -1);
        run_frame(32'h5555_5555, 32, -1);
        run_frame(32'hFFFF, 16, -1);
        run_frame(32'h3C, 6, 2);
        t_idle_lo_pulse();
        t_mid_reset();
        run_frame(32'h6, 3, -1);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule